// File: doc/BRIEF.md
# Interrupt Controller Base Register

This block is the model-specific base register of a local interrupt controller. It stores where the controller's 4 KiB register window sits in physical address space, a bootstrap-processor flag, a global enable and an extended-mode enable. Software writes a full 64-bit value through a one-cycle write strobe. Each written value is screened before it is stored. Bits that are reserved fail the screen. Address bits above the implemented physical-address width fail the screen. A move between operating modes that is not allowed also fails the screen.

A rejected write leaves the register as it was. It raises `gp_fault` for exactly one cycle, which the core turns into a general-protection exception. An accepted write takes effect on the next clock edge. The block reports the current mode and the window base. It also compares a bus address against the window, so the memory-mapped registers follow the base whenever software moves it.

Top module: `lic_base_reg`

## Requirements
- R1: After reset `rd_data` is 0x00000000FEE00900, with the base at 0xFEE00000, the bootstrap flag set and the global enable set. `mode` reads legacy.
- R2: Field layout: bit 8 is the bootstrap flag, bit 10 is extended enable, bit 11 is global enable, and bits [PA_W-1:12] hold the base. An accepted write appears on `rd_data` one cycle after the strobe.
- R3: A write with any of bits 0 to 7 or bit 9 set is rejected.
- R4: A write with any bit at or above PA_W set (PA_W defaults to 36) is rejected.
- R5: A write with bit 10 set and bit 11 clear is rejected, whatever the current mode.
- R6: From extended mode, a write of bit 11 = 1 and bit 10 = 0 (legacy) is rejected.
- R7: From disabled mode, a write of bits 11 and 10 both set (extended) is rejected.
- R8: Some writes are accepted when no other rule rejects them: leaving extended mode for disabled, going from legacy to extended, and changing the base while the mode stays the same.
- R9: A rejected write leaves `rd_data`, `mode` and `base_addr` unchanged.
- R10: `gp_fault` is high for exactly the one cycle after a rejected write. It stays low after accepted writes and when no write is made.
- R11: `mode` encodes disabled as 0, legacy as 1 and extended as 2. It never reads 3.
- R12: `win_hit` is high only in legacy mode and only when `bus_addr[PA_W-1:12]` equals the stored base. After the base moves (for example to 0x42000000), the window follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 64 | Value proposed for the register |
| bus_addr | input | PA_W | Physical address to match against the window |
| rd_data | output | 64 | Current register contents |
| gp_fault | output | 1 | One-cycle pulse for a rejected write |
| mode | output | 2 | 0 disabled, 1 legacy, 2 extended |
| base_addr | output | PA_W | Window base address, low 12 bits zero |
| win_hit | output | 1 | `bus_addr` falls inside the active window |

## Verification
Directed writes go through every pair of current mode and requested mode. These writes show which transitions the mode screen rejects and which it accepts. Single reserved low bits and a single bit at PA_W are also written. Each is checked on its own, so the bench can tell the low-bit screen apart from the address-width screen.

Several hundred random writes follow. They mix valid flag combinations, random bases and occasional stray bits, and each is checked against a reference model. This shows that stored state and the fault pulse stay correct across long runs of mixed accepted and rejected writes.

Window probes are made in each mode, inside the window and one page beyond it, both before and after the base moves. They tell a correct base compare apart from a decode that ignores the mode or keeps the old base.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

   typedef enum logic [1:0] {
      LBR_OFF    = 2'd0,
      LBR_LEGACY = 2'd1,
      LBR_EXT    = 2'd2
   } lbr_mode_e;

   localparam int BIT_BSP  = 8;
   localparam int BIT_XEN  = 10;
   localparam int BIT_GEN  = 11;
   localparam int PAGE_LSB = 12;

   localparam logic [63:0] RESET_BASE = 64'h0000_0000_FEE0_0000;

   function automatic logic [63:0] valid_mask(input int pa_w);
      logic [63:0] m;
      m = ((64'd1 << pa_w) - 64'd1) & ~64'hFFF;
      m[BIT_BSP] = 1'b1;
      m[BIT_XEN] = 1'b1;
      m[BIT_GEN] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/lbr_rsvd_check.sv
module lbr_rsvd_check #(
   parameter int PA_W = 36
) (
   input  logic [63:0] wr_data,
   output logic        rsvd_err
);
   import lbr_pkg::*;

   localparam logic [63:0] RSVD = ~valid_mask(PA_W);

   logic [63:0] bad;

   for (genvar b = 0; b < 64; b++) begin : g_bit
      if (RSVD[b]) begin : g_rsvd
         assign bad[b] = wr_data[b];
      end else begin : g_ok
         assign bad[b] = 1'b0;
      end
   end

   assign rsvd_err = |bad;

endmodule

// File: rtl/lbr_mode_fsm.sv
module lbr_mode_fsm (
   input  lbr_pkg::lbr_mode_e cur_mode,
   input  logic               req_gen,
   input  logic               req_xen,
   output lbr_pkg::lbr_mode_e nxt_mode,
   output logic               trans_err
);
   import lbr_pkg::*;

   always_comb begin
      nxt_mode  = cur_mode;
      trans_err = 1'b0;
      if (req_xen && !req_gen) begin
         trans_err = 1'b1;
      end else begin
         unique case ({req_gen, req_xen})
            2'b00:   nxt_mode = LBR_OFF;
            2'b10:   nxt_mode = LBR_LEGACY;
            default: nxt_mode = LBR_EXT;
         endcase
         case (cur_mode)
            LBR_EXT:    if (nxt_mode == LBR_LEGACY) trans_err = 1'b1;
            LBR_OFF:    if (nxt_mode == LBR_EXT)    trans_err = 1'b1;
            default:    ;
         endcase
         if (trans_err) nxt_mode = cur_mode;
      end
   end

endmodule

// File: rtl/lbr_window.sv
module lbr_window #(
   parameter int PA_W          = 36,
   parameter bit DECODE_IN_EXT = 1'b0
) (
   input  lbr_pkg::lbr_mode_e    mode,
   input  logic [PA_W-13:0]      base_pg,
   input  logic [PA_W-1:0]       bus_addr,
   output logic                  win_hit
);
   import lbr_pkg::*;

   logic dec_en;
   logic unused_low;

   assign unused_low = ^bus_addr[PAGE_LSB-1:0];

   if (DECODE_IN_EXT) begin : g_dec_any
      assign dec_en = (mode != LBR_OFF);
   end else begin : g_dec_legacy
      assign dec_en = (mode == LBR_LEGACY);
   end

   assign win_hit = dec_en && (bus_addr[PA_W-1:PAGE_LSB] == base_pg);

endmodule

// File: rtl/lic_base_reg.sv
module lic_base_reg #(
   parameter int PA_W          = 36,
   parameter bit DECODE_IN_EXT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [63:0]     wr_data,
   input  logic [PA_W-1:0] bus_addr,
   output logic [63:0]     rd_data,
   output logic            gp_fault,
   output logic [1:0]      mode,
   output logic [PA_W-1:0] base_addr,
   output logic            win_hit
);
   import lbr_pkg::*;

   localparam int          PG_W  = PA_W - PAGE_LSB;
   localparam logic [63:0] VALID = valid_mask(PA_W);

   if (PA_W < 32 || PA_W > 63) begin : g_bad_pa_w
      $error("lic_base_reg: PA_W must lie in 32..63");
   end

   lbr_mode_e      mode_q, nxt_mode;
   logic           bsp_q;
   logic [PG_W-1:0] base_q;
   logic           rsvd_err, trans_err, reject;

   lbr_rsvd_check #(.PA_W(PA_W)) i_rsvd (
      .wr_data  (wr_data),
      .rsvd_err (rsvd_err)
   );

   lbr_mode_fsm i_fsm (
      .cur_mode  (mode_q),
      .req_gen   (wr_data[BIT_GEN]),
      .req_xen   (wr_data[BIT_XEN]),
      .nxt_mode  (nxt_mode),
      .trans_err (trans_err)
   );

   assign reject = rsvd_err | trans_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= LBR_LEGACY;
         bsp_q    <= 1'b1;
         base_q   <= RESET_BASE[PA_W-1:PAGE_LSB];
         gp_fault <= 1'b0;
      end else begin
         gp_fault <= wr_en & reject;
         if (wr_en && !reject) begin
            mode_q <= nxt_mode;
            bsp_q  <= wr_data[BIT_BSP];
            base_q <= wr_data[PA_W-1:PAGE_LSB];
         end
      end
   end

   always_comb begin
      rd_data                      = '0;
      rd_data[PA_W-1:PAGE_LSB]     = base_q;
      rd_data[BIT_BSP]             = bsp_q;
      rd_data[BIT_GEN]             = (mode_q != LBR_OFF);
      rd_data[BIT_XEN]             = (mode_q == LBR_EXT);
   end

   assign mode      = mode_q;
   assign base_addr = {base_q, {PAGE_LSB{1'b0}}};

   lbr_window #(.PA_W(PA_W), .DECODE_IN_EXT(DECODE_IN_EXT)) i_win (
      .mode     (mode_q),
      .base_pg  (base_q),
      .bus_addr (bus_addr),
      .win_hit  (win_hit)
   );

   // Assertions
   p_mode_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);

   p_fault_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> $past(wr_en));

   p_fault_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> $stable(rd_data));

   p_no_ext_to_legacy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode) == 2'd2 |-> mode != 2'd1);

   p_no_off_to_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode) == 2'd0 |-> mode != 2'd2);

   p_rsvd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~VALID) == 64'd0);

   p_no_invalid_combo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_data[BIT_XEN] && !rd_data[BIT_GEN]));

   p_hit_in_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> (DECODE_IN_EXT ? (mode != 2'd0) : (mode == 2'd1)));

endmodule

// File: tb/test_lic_base_reg.sv
`timescale 1ns/1ps
module test_lic_base_reg;

   localparam int PA_W = 36;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [63:0]     wr_data = '0;
   logic [PA_W-1:0] bus_addr = '0;
   logic [63:0]     rd_data;
   logic            gp_fault;
   logic [1:0]      mode;
   logic [PA_W-1:0] base_addr;
   logic            win_hit;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [63:0] model;

   always #2 clk = ~clk;

   lic_base_reg #(.PA_W(PA_W)) i_lic_base_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .bus_addr(bus_addr), .rd_data(rd_data), .gp_fault(gp_fault),
      .mode(mode), .base_addr(base_addr), .win_hit(win_hit)
   );

   function automatic logic [63:0] valid_bits();
      logic [63:0] m;
      m = ((64'd1 << PA_W) - 64'd1) & ~64'hFFF;
      m[8] = 1'b1; m[10] = 1'b1; m[11] = 1'b1;
      return m;
   endfunction

   function automatic bit accept(logic [63:0] cur, logic [63:0] w);
      if ((w & ~valid_bits()) != 64'd0) return 1'b0;
      if (w[10] && !w[11]) return 1'b0;
      if (cur[11] && cur[10] && w[11] && !w[10]) return 1'b0;
      if (!cur[11] && w[11] && w[10]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [1:0] mode_of(logic [63:0] r);
      return !r[11] ? 2'd0 : (r[10] ? 2'd2 : 2'd1);
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // write at a negedge, captured at next posedge, checked at following negedge
   task automatic do_write(logic [63:0] w, string req);
      bit acc;
      acc = accept(model, w);
      @(negedge clk);
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
      if (acc) model = w;
      chk(rd_data == model, req, rd_data, model);
      chk(gp_fault == !acc, {req, " R10 fault"}, 64'(gp_fault), 64'(!acc));
      chk(mode == mode_of(model), {req, " R11 mode"}, 64'(mode), 64'(mode_of(model)));
      @(negedge clk);
      chk(gp_fault == 1'b0, "R10 pulse width", 64'(gp_fault), 64'd0);
   endtask

   task automatic probe(logic [PA_W-1:0] a, string req);
      bit exp;
      bus_addr = a;
      #0.5;
      exp = (mode_of(model) == 2'd1) && (a[PA_W-1:12] == model[PA_W-1:12]);
      chk(win_hit == exp, req, 64'(win_hit), 64'(exp));
   endtask

   initial begin
      #(4.0 * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [63:0] w;
      void'($urandom(32'd1234));
      model = 64'h0000_0000_FEE0_0900;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data == 64'h0000_0000_FEE0_0900, "R1 reset value", rd_data, 64'hFEE00900);
      chk(mode == 2'd1, "R1 reset mode", 64'(mode), 64'd1);
      chk(gp_fault == 1'b0, "R10 idle", 64'(gp_fault), 64'd0);
      probe(36'h0_FEE0_0040, "R12 hit at reset base");

      do_write(64'hFEE00901, "R3 bit0");
      do_write(64'hFEE00B00, "R3 bit9");
      do_write(64'hFEE00980, "R3 bit7");
      do_write(64'hFEE00900 | (64'd1 << PA_W), "R4 bit PA_W");
      do_write(64'hFEE00900 | (64'd1 << 63), "R4 bit63");
      do_write(64'hFEE00500, "R5 from legacy");
      do_write(64'hFEE00D00, "R8 legacy to extended");
      chk(base_addr == 36'h0_FEE0_0000, "R2 base_addr", 64'(base_addr), 64'hFEE00000);
      probe(36'h0_FEE0_0040, "R12 no hit in extended");
      do_write(64'hFEE00900, "R6 extended to legacy");
      do_write(64'hFEE00400, "R5 from extended");
      do_write(64'h12340D00, "R8 base move in extended");
      do_write(64'hFEE00100, "R8 extended to disabled");
      probe(36'h0_FEE0_0040, "R12 no hit when disabled");
      do_write(64'hFEE00D00, "R7 disabled to extended");
      do_write(64'hFEE00400, "R5 from disabled");
      do_write(64'h42000900, "R2 R12 relocate to legacy");
      probe(36'h0_4200_0030, "R12 hit at new base");
      probe(36'h0_FEE0_0030, "R12 miss at old base");
      probe(36'h0_4200_1000, "R12 miss next page");
      do_write(64'h0000_000F_FFFF_F800, "R2 top base bits");
      probe(36'hF_FFFF_FFFC, "R12 hit top page");

      for (int i = 0; i < 400; i++) begin
         w = {$urandom, $urandom} & (((64'd1 << PA_W) - 64'd1) & ~64'hFFF);
         w[8]  = 1'($urandom);
         w[10] = 1'($urandom);
         w[11] = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 7) == 0) w = w | (64'd1 << $urandom_range(0, 63));
         do_write(w, "R9 random write");
         if (i % 8 == 0) begin
            probe(model[PA_W-1:0] | 36'($urandom_range(0, 4095)), "R12 random inside");
            probe(model[PA_W-1:0] ^ 36'h0_0000_1000, "R12 random outside");
         end
      end

      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model = 64'hFEE00900;
      @(negedge clk);
      chk(rd_data == 64'hFEE00900, "R1 second reset", rd_data, 64'hFEE00900);
      finish_run();
   end

endmodule